// File: doc/BRIEF.md
# Processor Operating Mode Summary Unit

This block condenses a handful of architectural control bits into one registered mode-summary word for an instruction decoder and address-generation logic to read. From the long-mode-active bit, the protection-enable and paging control bits, the code-segment attributes, the stack-segment size flag and the virtual-8086 flag, it derives several values:

- the operating mode and submode;
- the current privilege level;
- the paging and protection flags;
- the default and alternate operand sizes;
- the default and alternate address sizes;
- the stack width.

The summary is not updated continuously. It is refreshed only when a recompute strobe arrives. A store to the summary's own location counts as a recompute strobe, and the stored data is thrown away. Sizes are reported as 2-bit codes: 1 is 16-bit, 2 is 32-bit, 3 is 64-bit. Mode encoding: 0 legacy, 1 long. Submode encoding: 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit.

Top module: `mode_summary_unit`

## Requirements
- R1: While reset is high, every summary output and `sum_valid_o` are 0 from the next clock edge on.
- R2: With long-mode-active set, mode is 1 (long). Submode is 4 (64-bit) if the code-segment long flag is set, else 3 (compatibility).
- R3: With long-mode-active clear, mode is 0 (legacy). Submode is 0 (real) when protection-enable is 0. It is 1 (virtual-8086) when protection-enable is 1 and the VM flag is 1. Otherwise it is 2 (protected).
- R4: The privilege output equals the code-segment DPL. The paging output equals the paging bit. The protection output equals the protection-enable bit.
- R5: The operand size codes (default/alternate) are 2/1 in 64-bit submode or when the code-segment default-size flag is set, and 1/2 otherwise.
- R6: The address size codes (default/alternate) are 3/2 in 64-bit submode. Otherwise they are 2/1 when the code-segment default-size flag is set, and 1/2 when it is clear.
- R7: The stack size code is 3 in 64-bit submode. Otherwise it is 2 if the stack-segment default-size flag is set, and 1 if it is clear.
- R8: Outputs change only on the clock edge after a cycle in which `recompute_i` or `sum_wr_i` is high. They reflect the inputs sampled at that edge. In all other cycles they hold, whatever the inputs do.
- R9: A cycle with `sum_wr_i` high recomputes exactly as `recompute_i` would. The value on `sum_wdata_i` has no effect on any output.
- R10: `sum_valid_o` is high for exactly the one cycle after each strobe cycle. A cycle with both strobes high gives a single update and a single valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| recompute_i | input | 1 | Recompute strobe |
| sum_wr_i | input | 1 | Store to the summary location (acts as recompute) |
| sum_wdata_i | input | WDATA_W | Store data, discarded |
| lma_i | input | 1 | Long mode active |
| pe_i | input | 1 | Protection-enable control bit |
| pg_i | input | 1 | Paging control bit |
| vm_i | input | 1 | Virtual-8086 flag |
| cs_long_i | input | 1 | Code segment long flag |
| cs_big_i | input | 1 | Code segment default-size flag |
| cs_dpl_i | input | 2 | Code segment descriptor privilege level |
| ss_big_i | input | 1 | Stack segment default-size flag |
| mode_o | output | 1 | 0 legacy, 1 long |
| submode_o | output | 3 | Submode code |
| cpl_o | output | 2 | Current privilege level |
| paging_o | output | 1 | Paging on |
| prot_o | output | 1 | Protection on |
| op_def_o | output | 2 | Default operand size code |
| op_alt_o | output | 2 | Alternate operand size code |
| addr_def_o | output | 2 | Default address size code |
| addr_alt_o | output | 2 | Alternate address size code |
| stack_o | output | 2 | Stack size code |
| sum_valid_o | output | 1 | One-cycle pulse after an update |

## Verification
Two events can fall in the same cycle: a plain recompute strobe and a store to the summary location. The bench raises both together, with store data of all ones and of alternating patterns. It expects one update, computed from the control inputs alone, and a single one-cycle valid pulse. The bench also changes the control inputs in cycles without a strobe. It then checks on every clock, against its own model, that the outputs hold.

// File: rtl/mode_summary_pkg.sv
package mode_summary_pkg;

    localparam int CPL_W = 2;

    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_LONG   = 1'b1
    } op_mode_e;

    typedef enum logic [2:0] {
        SUB_REAL   = 3'd0,
        SUB_V86    = 3'd1,
        SUB_PROT   = 3'd2,
        SUB_COMPAT = 3'd3,
        SUB_64     = 3'd4
    } sub_mode_e;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_16   = 2'd1,
        SZ_32   = 2'd2,
        SZ_64   = 2'd3
    } size_code_e;

    typedef struct packed {
        logic             lma;
        logic             pe;
        logic             pg;
        logic             vm;
        logic             cs_long;
        logic             cs_big;
        logic [CPL_W-1:0] cs_dpl;
        logic             ss_big;
    } ctl_state_t;

    typedef struct packed {
        op_mode_e  mode;
        sub_mode_e sub;
    } mode_pair_t;

    typedef struct packed {
        size_code_e def_sz;
        size_code_e alt_sz;
    } size_pair_t;

    typedef struct packed {
        op_mode_e         mode;
        sub_mode_e        sub;
        logic [CPL_W-1:0] cpl;
        logic             paging;
        logic             prot;
        size_pair_t       opnd;
        size_pair_t       addr;
        size_code_e       stack;
    } mode_summary_t;

    function automatic mode_pair_t classify(input ctl_state_t c);
        mode_pair_t r;
        if (c.lma) begin
            r.mode = MODE_LONG;
            r.sub  = c.cs_long ? SUB_64 : SUB_COMPAT;
        end else begin
            r.mode = MODE_LEGACY;
            if (!c.pe)      r.sub = SUB_REAL;
            else if (c.vm)  r.sub = SUB_V86;
            else            r.sub = SUB_PROT;
        end
        return r;
    endfunction

    function automatic size_pair_t swap_pair(input logic wide);
        size_pair_t p;
        p.def_sz = wide ? SZ_32 : SZ_16;
        p.alt_sz = wide ? SZ_16 : SZ_32;
        return p;
    endfunction

endpackage

// File: rtl/mode_classify.sv
module mode_classify
    import mode_summary_pkg::*;
(
    input  ctl_state_t ctl_i,
    output mode_pair_t pair_o
);
    always_comb pair_o = classify(ctl_i);
endmodule

// File: rtl/size_select.sv
module size_select
    import mode_summary_pkg::*;
(
    input  sub_mode_e  sub_i,
    input  logic       cs_big_i,
    input  logic       ss_big_i,
    output size_pair_t opnd_o,
    output size_pair_t addr_o,
    output size_code_e stack_o
);
    logic in64;
    assign in64 = (sub_i == SUB_64);

    always_comb begin
        opnd_o = swap_pair(in64 || cs_big_i);
        if (in64) begin
            addr_o.def_sz = SZ_64;
            addr_o.alt_sz = SZ_32;
            stack_o       = SZ_64;
        end else begin
            addr_o  = swap_pair(cs_big_i);
            stack_o = ss_big_i ? SZ_32 : SZ_16;
        end
    end
endmodule

// File: rtl/summary_reg.sv
module summary_reg
    import mode_summary_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  mode_summary_t next_i,
    output mode_summary_t cur_o,
    output logic          valid_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= load_i;
            if (load_i) cur_o <= next_i;
        end
    end
endmodule

// File: rtl/mode_summary_unit.sv
module mode_summary_unit
    import mode_summary_pkg::*;
#(
    parameter int WDATA_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               recompute_i,
    input  logic               sum_wr_i,
    input  logic [WDATA_W-1:0] sum_wdata_i,
    input  logic               lma_i,
    input  logic               pe_i,
    input  logic               pg_i,
    input  logic               vm_i,
    input  logic               cs_long_i,
    input  logic               cs_big_i,
    input  logic [1:0]         cs_dpl_i,
    input  logic               ss_big_i,
    output logic               mode_o,
    output logic [2:0]         submode_o,
    output logic [1:0]         cpl_o,
    output logic               paging_o,
    output logic               prot_o,
    output logic [1:0]         op_def_o,
    output logic [1:0]         op_alt_o,
    output logic [1:0]         addr_def_o,
    output logic [1:0]         addr_alt_o,
    output logic [1:0]         stack_o,
    output logic               sum_valid_o
);
    ctl_state_t    ctl;
    mode_pair_t    pair;
    size_pair_t    opnd, addr;
    size_code_e    stk;
    mode_summary_t nxt, cur;
    logic          load;
    logic          unused_wdata;

    // Store data is deliberately discarded; a store only triggers a refresh.
    assign unused_wdata = ^sum_wdata_i;
    assign load = recompute_i | sum_wr_i;

    always_comb begin
        ctl.lma     = lma_i;
        ctl.pe      = pe_i;
        ctl.pg      = pg_i;
        ctl.vm      = vm_i;
        ctl.cs_long = cs_long_i;
        ctl.cs_big  = cs_big_i;
        ctl.cs_dpl  = cs_dpl_i;
        ctl.ss_big  = ss_big_i;
    end

    mode_classify u_cls (.ctl_i(ctl), .pair_o(pair));

    size_select u_sz (
        .sub_i   (pair.sub),
        .cs_big_i(ctl.cs_big),
        .ss_big_i(ctl.ss_big),
        .opnd_o  (opnd),
        .addr_o  (addr),
        .stack_o (stk)
    );

    always_comb begin
        nxt.mode   = pair.mode;
        nxt.sub    = pair.sub;
        nxt.cpl    = ctl.cs_dpl;
        nxt.paging = ctl.pg;
        nxt.prot   = ctl.pe;
        nxt.opnd   = opnd;
        nxt.addr   = addr;
        nxt.stack  = stk;
    end

    summary_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .next_i (nxt),
        .cur_o  (cur),
        .valid_o(sum_valid_o)
    );

    assign mode_o     = cur.mode;
    assign submode_o  = cur.sub;
    assign cpl_o      = cur.cpl;
    assign paging_o   = cur.paging;
    assign prot_o     = cur.prot;
    assign op_def_o   = cur.opnd.def_sz;
    assign op_alt_o   = cur.opnd.alt_sz;
    assign addr_def_o = cur.addr.def_sz;
    assign addr_alt_o = cur.addr.alt_sz;
    assign stack_o    = cur.stack;
endmodule

// File: rtl/mode_summary_checker.sv
module mode_summary_checker (
    input logic       clk,
    input logic       rst,
    input logic       recompute_i,
    input logic       sum_wr_i,
    input logic       lma_i,
    input logic       pe_i,
    input logic       pg_i,
    input logic       cs_long_i,
    input logic [1:0] cs_dpl_i,
    input logic       mode_o,
    input logic [2:0] submode_o,
    input logic [1:0] cpl_o,
    input logic       paging_o,
    input logic       prot_o,
    input logic [1:0] stack_o,
    input logic [1:0] op_def_o,
    input logic       sum_valid_o
);
    logic strobe;
    assign strobe = recompute_i | sum_wr_i;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!sum_valid_o && mode_o == 1'b0 && submode_o == 3'd0 && stack_o == 2'd0));

    assert_long_mode_R2: assert property (@(posedge clk) disable iff (rst)
        (strobe && lma_i) |=> (mode_o && submode_o == ($past(cs_long_i) ? 3'd4 : 3'd3)));

    assert_real_mode_R3: assert property (@(posedge clk) disable iff (rst)
        (strobe && !lma_i && !pe_i) |=> (!mode_o && submode_o == 3'd0));

    assert_copies_R4: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (cpl_o == $past(cs_dpl_i) && paging_o == $past(pg_i) && prot_o == $past(pe_i)));

    assert_wide_ops_in_64_R5: assert property (@(posedge clk) disable iff (rst)
        (sum_valid_o && submode_o == 3'd4) |-> op_def_o == 2'd2);

    assert_stack_in_64_R7: assert property (@(posedge clk) disable iff (rst)
        (sum_valid_o && submode_o == 3'd4) |-> stack_o == 2'd3);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(mode_o) && $stable(submode_o) && $stable(cpl_o) && $stable(stack_o)));

    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        strobe |=> sum_valid_o);

    assert_valid_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> !sum_valid_o);
endmodule

bind mode_summary_unit mode_summary_checker u_chk (
    .clk(clk), .rst(rst), .recompute_i(recompute_i), .sum_wr_i(sum_wr_i),
    .lma_i(lma_i), .pe_i(pe_i), .pg_i(pg_i), .cs_long_i(cs_long_i),
    .cs_dpl_i(cs_dpl_i), .mode_o(mode_o), .submode_o(submode_o),
    .cpl_o(cpl_o), .paging_o(paging_o), .prot_o(prot_o), .stack_o(stack_o),
    .op_def_o(op_def_o), .sum_valid_o(sum_valid_o)
);

// File: tb/mode_summary_unit_tb.sv
`timescale 1ns/1ps
module mode_summary_unit_tb;
    localparam int W = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic recompute_i = 0, sum_wr_i = 0;
    logic [W-1:0] sum_wdata_i = '0;
    logic lma_i = 0, pe_i = 0, pg_i = 0, vm_i = 0, cs_long_i = 0, cs_big_i = 0, ss_big_i = 0;
    logic [1:0] cs_dpl_i = 0;
    logic mode_o, paging_o, prot_o, sum_valid_o;
    logic [2:0] submode_o;
    logic [1:0] cpl_o, op_def_o, op_alt_o, addr_def_o, addr_alt_o, stack_o;

    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;

    // reference state
    int e_mode, e_sub, e_cpl, e_pg, e_pe, e_od, e_oa, e_ad, e_aa, e_st, e_v;

    always #5 clk = ~clk;

    mode_summary_unit #(.WDATA_W(W)) u_dut (
        .clk(clk), .rst(rst), .recompute_i(recompute_i), .sum_wr_i(sum_wr_i),
        .sum_wdata_i(sum_wdata_i), .lma_i(lma_i), .pe_i(pe_i), .pg_i(pg_i),
        .vm_i(vm_i), .cs_long_i(cs_long_i), .cs_big_i(cs_big_i), .cs_dpl_i(cs_dpl_i),
        .ss_big_i(ss_big_i), .mode_o(mode_o), .submode_o(submode_o), .cpl_o(cpl_o),
        .paging_o(paging_o), .prot_o(prot_o), .op_def_o(op_def_o), .op_alt_o(op_alt_o),
        .addr_def_o(addr_def_o), .addr_alt_o(addr_alt_o), .stack_o(stack_o),
        .sum_valid_o(sum_valid_o)
    );

    // Behavioural reference model, updated at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            e_mode = 0; e_sub = 0; e_cpl = 0; e_pg = 0; e_pe = 0;
            e_od = 0; e_oa = 0; e_ad = 0; e_aa = 0; e_st = 0; e_v = 0;
        end else begin
            e_v = (recompute_i || sum_wr_i) ? 1 : 0;
            if (e_v == 1) begin
                if (lma_i) begin
                    e_mode = 1;
                    e_sub  = cs_long_i ? 4 : 3;
                end else begin
                    e_mode = 0;
                    if (!pe_i) e_sub = 0;
                    else e_sub = vm_i ? 1 : 2;
                end
                e_cpl = cs_dpl_i; e_pg = pg_i; e_pe = pe_i;
                if (e_sub == 4 || cs_big_i) begin e_od = 2; e_oa = 1; end
                else begin e_od = 1; e_oa = 2; end
                if (e_sub == 4) begin e_ad = 3; e_aa = 2; end
                else if (cs_big_i) begin e_ad = 2; e_aa = 1; end
                else begin e_ad = 1; e_aa = 2; end
                if (e_sub == 4) e_st = 3;
                else e_st = ss_big_i ? 2 : 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        cycles++;
        if (!finished) begin
            chk("R2/R3 mode", mode_o, e_mode);
            chk("R2/R3 submode", submode_o, e_sub);
            chk("R4 cpl", cpl_o, e_cpl);
            chk("R4 paging", paging_o, e_pg);
            chk("R4 prot", prot_o, e_pe);
            chk("R5 op_def", op_def_o, e_od);
            chk("R5 op_alt", op_alt_o, e_oa);
            chk("R6 addr_def", addr_def_o, e_ad);
            chk("R6 addr_alt", addr_alt_o, e_aa);
            chk("R7 stack", stack_o, e_st);
            chk("R10 valid", sum_valid_o, e_v);
        end
        if (cycles > 100000 && !finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic set_ctl(input logic [8:0] v);
        {lma_i, pe_i, pg_i, vm_i, cs_long_i, cs_big_i, cs_dpl_i, ss_big_i} = v;
    endtask

    task automatic step(input logic rc, input logic wr, input logic [W-1:0] wd);
        @(negedge clk);
        recompute_i = rc; sum_wr_i = wr; sum_wdata_i = wd;
    endtask

    initial begin
        // R1: reset
        repeat (3) @(negedge clk);
        chk("R1 reset valid", sum_valid_o, 0);
        chk("R1 reset submode", submode_o, 0);
        chk("R1 reset stack", stack_o, 0);
        rst = 0;

        // R3: real, v86, protected
        set_ctl(9'b0_0_0_0_0_0_00_0); step(1, 0, '0); step(0, 0, '0);
        set_ctl(9'b0_1_1_1_0_0_11_1); step(1, 0, '0); step(0, 0, '0);
        set_ctl(9'b0_1_0_0_1_1_01_1); step(1, 0, '0); step(0, 0, '0);
        // R2: compatibility then 64-bit (R5 R6 R7 in 64-bit)
        set_ctl(9'b1_1_1_0_0_1_10_0); step(1, 0, '0); step(0, 0, '0);
        set_ctl(9'b1_1_1_0_1_0_00_0); step(1, 0, '0); step(0, 0, '0);
        // R8: inputs change without strobe; outputs must hold
        set_ctl(9'b0_0_0_1_0_1_11_1); step(0, 0, '0);
        set_ctl(9'b0_1_0_1_0_0_01_0); step(0, 0, '0); step(0, 0, '0);
        // R9: store triggers recompute, data ignored
        step(0, 1, {W{1'b1}}); step(0, 0, '0);
        set_ctl(9'b1_1_1_0_0_0_11_1); step(0, 1, {(W/2){2'b10}}); step(0, 0, '0);
        // R10: both strobes in one cycle; then back-to-back strobes
        set_ctl(9'b0_1_1_0_0_1_10_1); step(1, 1, {(W/2){2'b01}}); step(0, 0, '0);
        step(1, 0, '0); set_ctl(9'b1_1_0_0_1_1_00_1); step(0, 1, '1); step(0, 0, '0);
        // Sweep all control combinations, mixing strobe kinds
        for (int i = 0; i < 512; i++) begin
            set_ctl(i[8:0]);
            step(i[0] ^ i[3], i[1], {W{i[2]}});
        end
        step(0, 0, '0); step(0, 0, '0);
        // R1 again: reset mid-run clears state
        rst = 1; step(0, 0, '0); step(0, 0, '0);
        chk("R1 reset after run", {mode_o, submode_o}, 0);
        rst = 0; step(0, 0, '0);
        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule